// File: doc/BRIEF.md
# Reloading Interval Timer with Prioritised Interrupt

This block is a 16-bit up-counting interval timer with its own interrupt request. A fixed-rate tick strobe arrives as an input. A separate circuit divides the system clock down to 160 kHz and delivers that strobe. While the timer runs, each tick moves the live count up by one. When the count passes 0xFFFF it reloads a software-chosen start value and flags an interrupt. The interval in ticks is 65536 minus the start value. At 160 kHz, a rate of f Hz needs a start value of 65536 - 160000/f, and a period of t microseconds needs 65536 - 160000/(1000000/t).

Software reaches four registers through a plain synchronous port. A write takes effect at the clock edge where the write strobe is high. Read data follows the address combinationally in the default build. The four registers are:

- the start value;
- the live count, which is read-only;
- a control byte that holds the timer cleared or lets it run;
- an interrupt byte that holds a 3-bit level, an enable bit and a pending flag. Software clears the pending flag by writing a one to it.

Top module: `ptmr_top`

## Requirements
- R1: After reset every register reads zero, and both `irq_req_o` and `irq_level_o` are zero.
- R2: Address map: 0 is the start value (read/write, 16 bits), 1 is the live count (read-only; writes are ignored), 2 is the control byte (bits [1:0] stored, other bits read zero), and 3 is the interrupt byte. Addresses 4 to 7 read zero.
- R3: Writing the control byte with bit 0 clear (for example 0x00) forces the count to zero at that edge. The count then stays at zero.
- R4: Writing the control byte with bit 0 set, while the stored bit 0 is clear, loads the count from the start value at that edge.
- R5: While control bits [1:0] equal 3 (written as 0x03), each tick raises the count by one. With any other control value, ticks leave the count unchanged.
- R6: A tick that arrives while running with the count at 0xFFFF loads the start value, not zero, and sets the pending flag.
- R7: In the interrupt byte, bits [2:0] are the level, bit 3 is the enable and bit 7 is the pending flag. Bits 6:4 read zero. A write stores the level and the enable. If written bit 7 is one the write clears the pending flag; if it is zero the flag is left unchanged.
- R8: `irq_req_o` is high exactly when the pending flag and the enable are both set. `irq_level_o` carries the level while `irq_req_o` is high and is zero otherwise.
- R9: If an acknowledge write and an overflow happen at the same edge, the pending flag stays set.
- R10: Writing the start value while the timer runs does not change the live count. The new value is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle 160 kHz count strobe |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` |
| irq_req_o | output | 1 | Interrupt request |
| irq_level_o | output | 3 | Priority level of the request |

## Verification
The properties assume that the bus makes at most one write per cycle. They also assume that the tick is an ordinary input whose pattern is arbitrary and may fall in the same cycle as a write. The stimulus keeps within this by driving a single address per cycle. It also lets ticks, control writes and acknowledges coincide freely, so that reloads, clears and acknowledges collide with overflows. Start values are drawn mostly from just below 0xFFFF, so that overflows happen often within the random run.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
   // register offsets (word addresses)
   localparam int unsigned ADR_START = 0;
   localparam int unsigned ADR_COUNT = 1;
   localparam int unsigned ADR_CTRL  = 2;
   localparam int unsigned ADR_IRQ   = 3;

   // control byte fields
   localparam int unsigned CTL_RELEASE_BIT = 0;
   localparam int unsigned CTL_RUN_BIT     = 1;

   // interrupt byte fields
   localparam int unsigned IRQ_EN_BIT   = 3;
   localparam int unsigned IRQ_PEND_BIT = 7;

   typedef struct packed {
      logic run;
      logic release_n_clr;
   } ctl_t;
endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
   import ptmr_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  start_val,
   output ctl_t              ctl,
   output logic              clr_now,
   output logic              load_now,
   output logic              irq_we
);
   logic wr_start, wr_ctl;

   always_comb begin
      wr_start = we && (addr == ADDR_W'(ADR_START));
      wr_ctl   = we && (addr == ADDR_W'(ADR_CTRL));
      irq_we   = we && (addr == ADDR_W'(ADR_IRQ));
      clr_now  = wr_ctl && !wdata[CTL_RELEASE_BIT];
      load_now = wr_ctl && wdata[CTL_RELEASE_BIT] && !ctl.release_n_clr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_val <= '0;
         ctl       <= '0;
      end else begin
         if (wr_start) start_val <= wdata[CNT_W-1:0];
         if (wr_ctl) begin
            ctl.release_n_clr <= wdata[CTL_RELEASE_BIT];
            ctl.run           <= wdata[CTL_RUN_BIT];
         end
      end
   end
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             running,
   input  logic             clr_now,
   input  logic             load_now,
   input  logic [CNT_W-1:0] start_val,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   logic advance;

   always_comb begin
      advance = tick && running && !clr_now && !load_now;
      ovf     = advance && (count == TOP);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        count <= '0;
      else if (clr_now)  count <= '0;
      else if (load_now) count <= start_val;
      else if (ovf)      count <= start_val;
      else if (advance)  count <= count + 1'b1;
   end
endmodule

// File: rtl/ptmr_irq.sv
module ptmr_irq
   import ptmr_pkg::*;
#(
   parameter int unsigned LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_we,
   input  logic [7:0]       wbyte,
   input  logic             ovf,
   output logic             pend,
   output logic             en,
   output logic [LVL_W-1:0] lvl,
   output logic             irq_req,
   output logic [LVL_W-1:0] irq_level
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         en   <= 1'b0;
         lvl  <= '0;
      end else begin
         if (irq_we) begin
            lvl <= wbyte[LVL_W-1:0];
            en  <= wbyte[IRQ_EN_BIT];
         end
         if (ovf)                              pend <= 1'b1;
         else if (irq_we && wbyte[IRQ_PEND_BIT]) pend <= 1'b0;
      end
   end

   always_comb begin
      irq_req   = pend && en;
      irq_level = irq_req ? lvl : '0;
   end
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
   import ptmr_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned LVL_W    = 3,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned DATA_W   = 16,
   parameter bit          RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_req_o,
   output logic [LVL_W-1:0]  irq_level_o
);
   localparam int unsigned PAD_IRQ = IRQ_PEND_BIT - IRQ_EN_BIT - 1;

   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("ptmr_top: CNT_W must fit in DATA_W");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("ptmr_top: DATA_W must hold a control byte");
   end
   if (LVL_W != IRQ_EN_BIT) begin : g_bad_lvl
      $error("ptmr_top: LVL_W must end just below the enable bit");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ptmr_top: ADDR_W too small for four registers");
   end

   logic [CNT_W-1:0] start_val, count;
   ctl_t             ctl;
   logic             clr_now, load_now, irq_we, ovf, running;
   logic             pend, en;
   logic [LVL_W-1:0] lvl;
   logic [DATA_W-1:0] rd_mux;

   ptmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we_i), .addr(bus_addr_i),
      .wdata(bus_wdata_i), .start_val(start_val), .ctl(ctl),
      .clr_now(clr_now), .load_now(load_now), .irq_we(irq_we)
   );

   assign running = ctl.release_n_clr && ctl.run;

   ptmr_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .tick(tick_i), .running(running),
      .clr_now(clr_now), .load_now(load_now), .start_val(start_val),
      .count(count), .ovf(ovf)
   );

   ptmr_irq #(.LVL_W(LVL_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .irq_we(irq_we), .wbyte(bus_wdata_i[7:0]),
      .ovf(ovf), .pend(pend), .en(en), .lvl(lvl),
      .irq_req(irq_req_o), .irq_level(irq_level_o)
   );

   always_comb begin
      rd_mux = '0;
      case (bus_addr_i)
         ADDR_W'(ADR_START): rd_mux = DATA_W'(start_val);
         ADDR_W'(ADR_COUNT): rd_mux = DATA_W'(count);
         ADDR_W'(ADR_CTRL):  rd_mux = DATA_W'({ctl.run, ctl.release_n_clr});
         ADDR_W'(ADR_IRQ):   rd_mux = DATA_W'({pend, {PAD_IRQ{1'b0}}, en, lvl});
         default:            rd_mux = '0;
      endcase
   end

   if (RDATA_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) bus_rdata_o <= '0;
         else        bus_rdata_o <= rd_mux;
      end
   end else begin : g_rd_comb
      assign bus_rdata_o = rd_mux;
   end
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned LVL_W  = 3,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [CNT_W-1:0]  count,
   input logic              ovf,
   input logic              pend,
   input logic              en,
   input logic              running,
   input logic              irq_req,
   input logic [LVL_W-1:0]  irq_level
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   // R6
   ovf_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> pend);
   // R6
   ovf_only_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> (count == TOP && tick && running));
   // R3
   clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(2) && !wdata[0]) |=> (count == '0));
   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !we) |=> $stable(count));
   // R5
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tick && !we && count != TOP) |=> (count == $past(count) + 1'b1));
   // R8
   req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (pend && en));
   // R8
   level_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (irq_level == '0));
   // R9
   ack_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && we && addr == ADDR_W'(3) && wdata[7]) |=> pend);
endmodule

bind ptmr_top ptmr_chk #(
   .CNT_W(CNT_W), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick_i), .we(bus_we_i),
   .addr(bus_addr_i), .wdata(bus_wdata_i), .count(count), .ovf(ovf),
   .pend(pend), .en(en), .running(running),
   .irq_req(irq_req_o), .irq_level(irq_level_o)
);

// File: tb/sim_ptmr_top.sv
module sim_ptmr_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        we = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq_req;
   logic [2:0]  irq_level;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model of the register state
   logic [15:0] m_start, m_cnt;
   logic        m_rel, m_run, m_pend, m_en;
   logic [2:0]  m_lvl;

   ptmr_top u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_we_i(we),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .irq_req_o(irq_req), .irq_level_o(irq_level)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] next_cnt(input logic [15:0] c, input logic [15:0] s);
      return (c == 16'hFFFF) ? s : c + 16'd1;
   endfunction

   function automatic logic [15:0] irq_byte();
      return {8'h00, m_pend, 3'b000, m_en, m_lvl};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_start = '0; m_cnt = '0; m_rel = 0; m_run = 0;
      m_pend = 0; m_en = 0; m_lvl = '0;
   endtask

   // one clock with given stimulus; model follows the requirements
   task automatic step(input bit t, input bit w, input logic [2:0] a, input logic [15:0] d);
      bit clr, ld, ov;
      tick = t; we = w; addr = a; wdata = d;
      @(posedge clk);
      ov  = 0;
      clr = w && a == 3'd2 && !d[0];
      ld  = w && a == 3'd2 && d[0] && !m_rel;
      if (clr)      m_cnt = '0;
      else if (ld)  m_cnt = m_start;
      else if (t && m_rel && m_run) begin
         ov    = (m_cnt == 16'hFFFF);
         m_cnt = next_cnt(m_cnt, m_start);
      end
      if (w && a == 3'd0) m_start = d;
      if (w && a == 3'd2) begin m_rel = d[0]; m_run = d[1]; end
      if (w && a == 3'd3) begin m_lvl = d[2:0]; m_en = d[3]; end
      if (ov) m_pend = 1'b1;
      else if (w && a == 3'd3 && d[7]) m_pend = 1'b0;
      @(negedge clk);
      tick = 0; we = 0; wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic check_all(input string tag);
      logic [15:0] v;
      rd(3'd0, v); chk(v == m_start, {tag, " R2 start"}, v, m_start);
      rd(3'd1, v); chk(v == m_cnt, {tag, " R5 count"}, v, m_cnt);
      rd(3'd2, v); chk(v == {14'd0, m_run, m_rel}, {tag, " R2 ctrl"}, v, {14'd0, m_run, m_rel});
      rd(3'd3, v); chk(v == irq_byte(), {tag, " R7 irq byte"}, v, irq_byte());
      chk(irq_req == (m_pend && m_en), {tag, " R8 req"}, {15'd0, irq_req}, {15'd0, m_pend && m_en});
      chk(irq_level == ((m_pend && m_en) ? m_lvl : 3'd0), {tag, " R8 level"},
          {13'd0, irq_level}, {13'd0, (m_pend && m_en) ? m_lvl : 3'd0});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'h5EED_1234));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int i = 0; i < 4; i++) begin
         rd(3'(i), v);
         chk(v == 16'h0, "R1 reset register", v, 16'h0);
      end
      chk(irq_req == 1'b0 && irq_level == 3'd0, "R1 reset irq outputs",
          {12'd0, irq_req, irq_level}, 16'h0);

      // R2: map, count read-only, unmapped reads zero
      step(0, 1, 3'd0, 16'hFFFC);
      rd(3'd0, v); chk(v == 16'hFFFC, "R2 start readback", v, 16'hFFFC);
      step(0, 1, 3'd1, 16'h1234);
      rd(3'd1, v); chk(v == 16'h0000, "R2 count write ignored", v, 16'h0000);
      step(0, 1, 3'd5, 16'hBEEF);
      rd(3'd5, v); chk(v == 16'h0000, "R2 unmapped reads zero", v, 16'h0000);
      step(0, 1, 3'd2, 16'h00FC);
      rd(3'd2, v); chk(v == 16'h0000, "R2 ctrl upper bits dropped", v, 16'h0000);

      // R4: release loads start value
      step(0, 1, 3'd2, 16'h0003);
      rd(3'd1, v); chk(v == 16'hFFFC, "R4 load on release", v, 16'hFFFC);
      // R5: three ticks reach top
      for (int i = 0; i < 3; i++) step(1, 0, 3'd0, 16'h0);
      rd(3'd1, v); chk(v == 16'hFFFF, "R5 counting", v, 16'hFFFF);
      // R6: overflow reloads and sets pending; R8 no request when disabled
      step(1, 0, 3'd0, 16'h0);
      rd(3'd1, v); chk(v == 16'hFFFC, "R6 reload value", v, 16'hFFFC);
      rd(3'd3, v); chk(v == 16'h0080, "R6 pending set", v, 16'h0080);
      chk(irq_req == 1'b0, "R8 disabled no request", {15'd0, irq_req}, 16'h0);

      // R7: enable + level without ack keeps pending; R8 request carries level
      step(0, 1, 3'd3, 16'h000D);
      rd(3'd3, v); chk(v == 16'h008D, "R7 write without ack", v, 16'h008D);
      chk(irq_req && irq_level == 3'd5, "R8 request level",
          {12'd0, irq_req, irq_level}, 16'h000D);
      // R7: acknowledge
      step(0, 1, 3'd3, 16'h008D);
      rd(3'd3, v); chk(v == 16'h000D, "R7 ack clears pending", v, 16'h000D);
      chk(!irq_req && irq_level == 3'd0, "R8 idle level zero",
          {12'd0, irq_req, irq_level}, 16'h0);

      // R9: ack and overflow together
      for (int i = 0; i < 3; i++) step(1, 0, 3'd0, 16'h0);
      step(1, 1, 3'd3, 16'h008D);
      rd(3'd3, v); chk(v == 16'h008D, "R9 overflow beats ack", v, 16'h008D);
      step(0, 1, 3'd3, 16'h008D);

      // R10: start value change while running
      step(1, 1, 3'd0, 16'hFFF0);
      rd(3'd1, v); chk(v == 16'hFFFD, "R10 count kept on start write", v, 16'hFFFD);
      for (int i = 0; i < 3; i++) step(1, 0, 3'd0, 16'h0);
      rd(3'd1, v); chk(v == 16'hFFF0, "R10 new value at reload", v, 16'hFFF0);

      // R3: clear; R5 ticks ignored when not running
      step(1, 1, 3'd2, 16'h0000);
      rd(3'd1, v); chk(v == 16'h0000, "R3 clear to zero", v, 16'h0000);
      for (int i = 0; i < 4; i++) step(1, 0, 3'd0, 16'h0);
      rd(3'd1, v); chk(v == 16'h0000, "R3 stays zero", v, 16'h0000);
      step(0, 1, 3'd2, 16'h0001);
      for (int i = 0; i < 4; i++) step(1, 0, 3'd0, 16'h0);
      rd(3'd1, v); chk(v == 16'hFFF0, "R5 held when run bit clear", v, 16'hFFF0);
      check_all("directed");

      // random phase
      for (int n = 0; n < 4000; n++) begin
         bit t, w;
         logic [2:0] a;
         logic [15:0] d;
         t = ($urandom % 2) == 0;
         w = ($urandom % 5) == 0;
         a = 3'($urandom % 5);
         d = 16'($urandom);
         case (a)
            3'd0: d = 16'hFFF0 | 16'($urandom % 16);
            3'd2: d = (($urandom % 4) != 0) ? 16'h0003 : 16'($urandom % 4);
            default: ;
         endcase
         step(t, w, a, d);
         if (n % 8 == 0) check_all("random");
      end
      check_all("final");
      finish_run();
   end
endmodule